// File: doc/BRIEF.md
# CRC4 Multiframe Alignment Searcher

Once a receiver has found frame alignment on a 2.048 Mbit/s link, this block finds the 16-frame CRC4 multiframe. For each frame it gets one bit: bit 1 of timeslot 0. It also gets a flag that says whether that frame carries the frame alignment signal. It looks only at frames without that signal and waits for the six-bit multiframe alignment word. Lock is declared when the word shows up a second time, exactly one multiframe after the first. If no lock comes within a search window counted in frames, the block asks for the frame search to be restarted. The window is shorter in test mode.

After lock, the block marks the start of every multiframe. The CRC4 checksum is computed elsewhere, and each compare result arrives as a strobe with an error flag. This block passes each error out as a pulse and keeps a saturating count that is cleared by a read strobe. In test mode it also watches the error density over blocks of CRC words. When too many words in a block are bad, it drops lock and asks for a frame-level resync.

Top module: `crc4_mf_search`

## Requirements
- R1: Only frames with `fas_frame`=0 are examined. `si_bit` in frames with `fas_frame`=1 has no effect on detection or lock.
- R2: The alignment word is 0,0,1,0,1,1, oldest first, taken from consecutive examined frames. A second word that ends exactly 8 examined frames (16 frames) after the first declares lock, and `mf_sync` is high from the cycle after that strobe. If the second word is missing at that point, the candidate is discarded.
- R3: The search window counts `frame_stb` pulses from the start of the search. On the 104th strobe without lock, `resync_req` pulses for one cycle and the search starts over.
- R4: With `test_mode`=1 the window is 64 strobes.
- R5: While locked, `mf_start` pulses for one cycle, in the cycle after the strobe of multiframe frame 0. The frame that completed the lock word is frame 11.
- R6: When `frm_lock` is low, lock and all search state are cleared, and `mf_sync` is low from the next cycle.
- R7: `crc_err_evt` is high in the cycle after a cycle in which `crc_done` and `crc_err` are both high, and low otherwise.
- R8: `err_count` is 10 bits wide. It counts each CRC error by one and holds at 1023.
- R9: `cnt_rd` clears `err_count` at the next edge. An error in the same cycle as the read leaves the count at 1.
- R10: While locked with `test_mode`=1, CRC words are grouped in blocks of 1000. If 915 or more words in a block are in error, then in the cycle after the last word `resync_req` pulses and `mf_sync` falls. With `test_mode`=0 this never happens.
- R11: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_lock | input | 1 | Frame alignment established; search runs while high |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| fas_frame | input | 1 | The strobed frame carries the frame alignment signal |
| si_bit | input | 1 | Bit 1 of timeslot 0 of the strobed frame |
| test_mode | input | 1 | Short search window and error-density resync |
| crc_done | input | 1 | One CRC4 word compare completed |
| crc_err | input | 1 | The completed compare failed |
| cnt_rd | input | 1 | Read strobe; clears the error count |
| mf_sync | output | 1 | CRC4 multiframe lock |
| mf_start | output | 1 | Start-of-multiframe pulse |
| resync_req | output | 1 | Request to restart frame search |
| crc_err_evt | output | 1 | One pulse per CRC error |
| err_count | output | 10 | Saturating CRC error count |

## Verification
Every output is a register, so each result is due exactly one cycle after the stimulus that causes it. This holds for lock, the start pulse, the timeout and density resyncs, the error pulse and the count update. The driver applies one stimulus per clock at the falling edge and queues the expected outputs, tagged with the cycle number at which they are due. The monitor pops each entry at the falling edge after the next rising edge, so it samples after exactly one register stage. Timeout and lock positions are worked out as frame indices from the scenario's start frame.

// File: rtl/crc4_mf_search.sv
module crc4_mf_search #(
  parameter logic [5:0] MFA_PAT  = 6'b001011,
  parameter int         WIN_NORM = 104,
  parameter int         WIN_TEST = 64,
  parameter int         BLK_LEN  = 1000,
  parameter int         BLK_THR  = 915,
  parameter int         CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_lock,
  input  logic             frame_stb,
  input  logic             fas_frame,
  input  logic             si_bit,
  input  logic             test_mode,
  input  logic             crc_done,
  input  logic             crc_err,
  input  logic             cnt_rd,
  output logic             mf_sync,
  output logic             mf_start,
  output logic             resync_req,
  output logic             crc_err_evt,
  output logic [CNT_W-1:0] err_count
);

  localparam int PAT_LEN = 6;
  localparam int GAP     = 8;
  localparam logic [3:0] LOCK_POS = 4'(2 * PAT_LEN - 1);
  localparam int WIN_MAX = (WIN_NORM > WIN_TEST) ? WIN_NORM : WIN_TEST;
  localparam int WW      = $clog2(WIN_MAX + 1);
  localparam int BW      = $clog2(BLK_LEN + 1);

  logic [PAT_LEN-1:0] sh;
  logic               cand;
  logic [2:0]         nf_cnt;
  logic [WW-1:0]      win_cnt;
  logic [3:0]         pos;
  logic [BW-1:0]      blk_cnt, blk_err;

  wire searching = frm_lock && !mf_sync;
  wire nfas_stb  = frame_stb && !fas_frame;
  wire [PAT_LEN-1:0] sh_nxt = {sh[PAT_LEN-2:0], si_bit};
  wire match     = nfas_stb && (sh_nxt == MFA_PAT);
  wire gap_end   = cand && (nf_cnt == 3'(GAP - 1));
  wire lock_now  = searching && match && gap_end;
  wire [WW-1:0] win_last = test_mode ? WW'(WIN_TEST - 1) : WW'(WIN_NORM - 1);
  wire timeout   = searching && frame_stb && !lock_now && (win_cnt == win_last);

  wire blk_on    = mf_sync && test_mode && frm_lock;
  wire blk_end   = blk_on && crc_done && (blk_cnt == BW'(BLK_LEN - 1));
  wire [BW-1:0] blk_err_n = blk_err + BW'(crc_err);
  wire crc_fail  = blk_end && (blk_err_n >= BW'(BLK_THR));
  wire sync_n    = frm_lock && (lock_now || (mf_sync && !crc_fail));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_sync    <= 1'b0;
      mf_start   <= 1'b0;
      resync_req <= 1'b0;
      pos        <= '0;
    end else begin
      mf_sync    <= sync_n;
      resync_req <= timeout || crc_fail;
      mf_start   <= frame_stb && mf_sync && sync_n && (pos == 4'd15);
      if (lock_now)       pos <= LOCK_POS;
      else if (frame_stb) pos <= pos + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '1;
      cand    <= 1'b0;
      nf_cnt  <= '0;
      win_cnt <= '0;
    end else if (!searching || timeout) begin
      sh      <= '1;
      cand    <= 1'b0;
      nf_cnt  <= '0;
      win_cnt <= '0;
    end else begin
      if (frame_stb) win_cnt <= win_cnt + 1'b1;
      if (nfas_stb) begin
        sh <= sh_nxt;
        if (cand) begin
          nf_cnt <= nf_cnt + 3'd1;
          if (gap_end) cand <= 1'b0;
        end else if (match) begin
          cand   <= 1'b1;
          nf_cnt <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
      blk_err <= '0;
    end else if (!blk_on || blk_end) begin
      blk_cnt <= '0;
      blk_err <= '0;
    end else if (crc_done) begin
      blk_cnt <= blk_cnt + 1'b1;
      blk_err <= blk_err_n;
    end
  end

  wire err_hit = crc_done && crc_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_err_evt <= 1'b0;
      err_count   <= '0;
    end else begin
      crc_err_evt <= err_hit;
      if (cnt_rd)
        err_count <= CNT_W'(err_hit);
      else if (err_hit && (err_count != {CNT_W{1'b1}}))
        err_count <= err_count + 1'b1;
    end
  end

endmodule

// File: rtl/crc4_mf_search_chk.sv
module crc4_mf_search_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frm_lock,
  input logic             frame_stb,
  input logic             fas_frame,
  input logic             si_bit,
  input logic             crc_done,
  input logic             crc_err,
  input logic             cnt_rd,
  input logic             mf_sync,
  input logic             mf_start,
  input logic             resync_req,
  input logic             crc_err_evt,
  input logic [CNT_W-1:0] err_count
);

  assert_lock_on_nfas_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_sync) |-> $past(frame_stb && !fas_frame && si_bit));

  assert_start_in_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> mf_sync);

  assert_lock_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_lock |=> !mf_sync);

  assert_resync_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> !mf_sync);

  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_done && crc_err) |=> crc_err_evt);

  assert_count_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cnt_rd) |-> (err_count >= $past(err_count)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rd && !crc_done) |=> (err_count == '0));

endmodule

bind crc4_mf_search crc4_mf_search_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .frm_lock(frm_lock), .frame_stb(frame_stb),
  .fas_frame(fas_frame), .si_bit(si_bit), .crc_done(crc_done),
  .crc_err(crc_err), .cnt_rd(cnt_rd), .mf_sync(mf_sync),
  .mf_start(mf_start), .resync_req(resync_req),
  .crc_err_evt(crc_err_evt), .err_count(err_count)
);

// File: tb/crc4_mf_search_tb_top.sv
module crc4_mf_search_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frm_lock = 1'b0, frame_stb = 1'b0, fas_frame = 1'b0, si_bit = 1'b0;
  logic test_mode = 1'b0, crc_done = 1'b0, crc_err = 1'b0, cnt_rd = 1'b0;
  logic mf_sync, mf_start, resync_req, crc_err_evt;
  logic [9:0] err_count;

  always #2.5 clk = ~clk;

  crc4_mf_search dut_i (
    .clk(clk), .rst_n(rst_n), .frm_lock(frm_lock), .frame_stb(frame_stb),
    .fas_frame(fas_frame), .si_bit(si_bit), .test_mode(test_mode),
    .crc_done(crc_done), .crc_err(crc_err), .cnt_rd(cnt_rd),
    .mf_sync(mf_sync), .mf_start(mf_start), .resync_req(resync_req),
    .crc_err_evt(crc_err_evt), .err_count(err_count)
  );

  typedef struct {
    int         due;
    logic       sync, start, rs, evt;
    logic [9:0] cnt;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] exp_cnt = '0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if ({mf_sync, mf_start, resync_req, crc_err_evt, err_count} !==
          {e.sync, e.start, e.rs, e.evt, e.cnt}) begin
        n_fail++;
        $display("FAIL %s cyc %0d: actual sync=%b start=%b rs=%b evt=%b cnt=%0d expected sync=%b start=%b rs=%b evt=%b cnt=%0d",
                 e.tag, cyc, mf_sync, mf_start, resync_req, crc_err_evt, err_count,
                 e.sync, e.start, e.rs, e.evt, e.cnt);
      end
    end
  end

  task automatic drive(input logic lk, stb, fas, si, cd, ce, rd,
                       input logic es, est, ers, input string tag);
    exp_t e;
    @(negedge clk);
    frm_lock = lk; frame_stb = stb; fas_frame = fas; si_bit = si;
    crc_done = cd; crc_err = ce; cnt_rd = rd;
    if (rd) exp_cnt = {9'd0, cd & ce};
    else if (cd && ce && exp_cnt != 10'h3ff) exp_cnt = exp_cnt + 10'd1;
    e.due = cyc + 1; e.sync = es; e.start = est; e.rs = ers;
    e.evt = cd & ce; e.cnt = exp_cnt; e.tag = tag;
    exp_q.push_back(e);
  endtask

  function automatic logic patbit(input int f);
    case (f)
      1, 3, 7: return 1'b0;
      5, 9, 11: return 1'b1;
      default: return 1'b1;
    endcase
  endfunction

  task automatic stream(input int f0, n, sync_at, bad_at, rs_at,
                        input bit swap, input string tag);
    for (int i = 0; i < n; i++) begin
      int f;
      logic fas, pat, si, es, est, ers;
      f   = (f0 + i) % 16;
      fas = (f % 2 == 0);
      pat = patbit(f);
      if (i == bad_at) pat = ~pat;
      if (swap) si = fas ? patbit(f + 1) : 1'b1;
      else      si = fas ? 1'($urandom % 2) : pat;
      es  = (sync_at >= 0) && (i >= sync_at);
      est = (sync_at >= 0) && (i > sync_at) && (f == 0);
      ers = (i == rs_at);
      drive(1, 1, fas, si, 0, 0, 0, es, est, ers, tag);
    end
  endtask

  task automatic unlock(input string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R11: outputs zero in and after reset
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 reset");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 reset");
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 after reset");

    // R2 R5: aligned from multiframe frame 0, lock on second word
    stream(0, 50, 27, -1, -1, 0, "R2 R5 aligned");
    unlock("R6 lock drop");

    // R2 R5: entry mid-multiframe
    stream(5, 45, 38, -1, -1, 0, "R2 R5 offset");
    unlock("R6 lock drop");

    // R1 R3: pattern only in FAS frames, normal window
    stream(0, 110, -1, -1, 103, 1, "R1 R3 timeout");
    unlock("R3 unlock");

    // R4: test-mode window
    test_mode = 1'b1;
    stream(0, 70, -1, -1, 63, 1, "R4 test timeout");
    unlock("R4 unlock");
    test_mode = 1'b0;

    // R2: corrupted second word discards candidate
    stream(0, 64, 59, 25, -1, 0, "R2 bad second");
    unlock("R6 unlock");

    // R10 R7 R8: dense errors in test mode force resync
    test_mode = 1'b1;
    stream(0, 28, 27, -1, -1, 0, "R10 lock");
    for (int k = 0; k < 1000; k++)
      drive(1, 0, 0, 0, 1, (k < 915), 0, (k < 999), 0, (k == 999), "R10 R7 R8 915");
    drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 after resync");
    unlock("R10 unlock");

    // R9 R10: read clears; 914 errors keep lock
    stream(0, 28, 27, -1, -1, 0, "R10 relock");
    drive(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9 read clear");
    for (int k = 0; k < 1000; k++)
      drive(1, 0, 0, 0, 1, (k < 914), 0, 1, 0, 0, "R10 914 holds");
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 idle");
    test_mode = 1'b0;
    drive(1, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R10 mode off");

    // R8 R10: normal mode saturates count, never resyncs
    for (int k = 0; k < 120; k++)
      drive(1, 0, 0, 0, 1, 1, 0, 1, 0, 0, "R8 R10 saturate");
    drive(1, 0, 0, 0, 1, 0, 0, 1, 0, 0, "R7 clean word");
    drive(1, 0, 0, 0, 1, 1, 1, 1, 0, 0, "R9 read with error");
    drive(1, 0, 0, 0, 0, 0, 1, 1, 0, 0, "R9 read");
    unlock("R6 final");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "end");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule